// File: doc/BRIEF.md
# Rotate-and-Mask Integer Execution Unit

This unit performs the word-sized rotate-then-mask operations of a RISC integer pipeline. A source word is rotated left by an amount taken either from a 5-bit immediate or from the low bits of a register operand. A contiguous run of ones, which may wrap around, is built from a pair of begin and end indices. The rotated word is then either ANDed with that run or merged into the previous destination value under it.

Begin and end indices count from the most significant bit: index 0 is bit 31. A record request also produces a four-bit condition update from a signed comparison of the result against zero. All operation logic is combinational. One registered stage with a valid strobe gives a fixed latency of one clock. Fetch, register-file access and exceptions belong to the surrounding pipeline.

Top module: `rotmask_unit`

## Requirements
- R1: Opcode 0x15 yields res_data = rotl(src_word, sh_imm) & mask.
- R2: Opcode 0x14 yields res_data = (rotl(src_word, sh_imm) & mask) | (old_dest & ~mask).
- R3: Opcode 0x17 rotates by amt_reg[4:0]; bits 31..5 of amt_reg have no effect on the result, and sh_imm is ignored.
- R4: A rotate amount of zero returns src_word unchanged before masking.
- R5: When msk_first <= msk_last, the mask holds ones at little-endian bit positions 31-msk_last through 31-msk_first inclusive, and zeros elsewhere.
- R6: When msk_first > msk_last, the mask wraps. It holds ones at positions 0 through 31-msk_first and at positions 31-msk_last through 31.
- R7: With upd_flags set on a legal opcode, flag_we is 1 and flag_val = {LT, GT, EQ, SO}. LT, GT and EQ come from a signed compare of res_data against zero, and SO (bit 0) copies sum_ovf_in.
- R8: With upd_flags clear, flag_we stays 0.
- R9: Any opcode other than 0x14, 0x15 or 0x17 sets bad_op, forces res_data to 0 and keeps flag_we at 0.
- R10: out_valid is in_valid delayed by exactly one clock, and the other outputs for an operation appear in that same cycle.
- R11: While rst is high, and on the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| ctl_opcode | input | 6 | Primary opcode |
| src_word | input | 32 | Word to rotate |
| amt_reg | input | 32 | Register rotate amount (low 5 bits used) |
| old_dest | input | 32 | Previous destination value for insert |
| sh_imm | input | 5 | Immediate rotate amount |
| msk_first | input | 5 | Mask begin index, MSB-first numbering |
| msk_last | input | 5 | Mask end index, MSB-first numbering |
| upd_flags | input | 1 | Record request |
| sum_ovf_in | input | 1 | Summary-overflow bit to copy |
| out_valid | output | 1 | Result valid |
| res_data | output | 32 | Operation result |
| flag_we | output | 1 | Condition field write enable |
| flag_val | output | 4 | {LT, GT, EQ, SO} |
| bad_op | output | 1 | Unsupported opcode |

## Verification
The only state is the output register, so any fault shows up one clock after the operation is presented. A wrong rotate stage corrupts every result whose amount has the matching bit set, so the bench uses amounts with different bit patterns. A mask decode fault shows only for some begin/end orderings, which is why non-wrapping, wrapping, single-bit and full masks are each tested. A stale or misrouted register would leave out_valid, flag_we or bad_op out of step with in_valid on the very next cycle.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_RL_INSERT = 6'h14;
  localparam logic [OPC_W-1:0] OPC_RL_AND    = 6'h15;
  localparam logic [OPC_W-1:0] OPC_RL_VAR    = 6'h17;

  typedef enum logic [1:0] {
    KIND_INSERT,
    KIND_AND,
    KIND_VAR,
    KIND_BAD
  } op_kind_e;

  function automatic op_kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_RL_INSERT: classify = KIND_INSERT;
      OPC_RL_AND:    classify = KIND_AND;
      OPC_RL_VAR:    classify = KIND_VAR;
      default:       classify = KIND_BAD;
    endcase
  endfunction
endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    assign stg[k+1] = amt[k] ? {stg[k][W-1-STEP:0], stg[k][W-1:W-STEP]} : stg[k];
  end

  assign dout = stg[SW];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [IW-1:0] first_idx,
  input  logic [IW-1:0] last_idx,
  output logic [W-1:0]  mask
);
  logic in_order;
  assign in_order = (first_idx <= last_idx);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [IW-1:0] BE_POS = IW'(W - 1 - i);
    logic ge_first, le_last;
    assign ge_first = (BE_POS >= first_idx);
    assign le_last  = (BE_POS <= last_idx);
    assign mask[i]  = in_order ? (ge_first & le_last) : (ge_first | le_last);
  end
endmodule

// File: rtl/rotmask_flags.sv
module rotmask_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic         ovf,
  output logic [3:0]   field
);
  logic is_zero, is_neg;
  assign is_zero = (value == '0);
  assign is_neg  = value[W-1];
  assign field   = {is_neg, ~is_neg & ~is_zero, is_zero, ovf};
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  ctl_opcode,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [DATA_W-1:0] old_dest,
  input  logic [SH_W-1:0]   sh_imm,
  input  logic [SH_W-1:0]   msk_first,
  input  logic [SH_W-1:0]   msk_last,
  input  logic              upd_flags,
  input  logic              sum_ovf_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              flag_we,
  output logic [3:0]        flag_val,
  output logic              bad_op
);
  op_kind_e          kind;
  logic [SH_W-1:0]   rot_amt;
  logic [DATA_W-1:0] rotated, mask, anded, merged, res_c;
  logic [3:0]        flags_c;
  logic              amt_hi_unused;

  assign kind          = classify(ctl_opcode);
  assign rot_amt       = (kind == KIND_VAR) ? amt_reg[SH_W-1:0] : sh_imm;
  assign amt_hi_unused = ^amt_reg[DATA_W-1:SH_W];

  rotmask_rotator #(.W(DATA_W), .SW(SH_W)) u_rot (
    .din(src_word), .amt(rot_amt), .dout(rotated)
  );

  rotmask_maskgen #(.W(DATA_W), .IW(SH_W)) u_mask (
    .first_idx(msk_first), .last_idx(msk_last), .mask(mask)
  );

  assign anded  = rotated & mask;
  assign merged = anded | (old_dest & ~mask);

  always_comb begin
    case (kind)
      KIND_INSERT: res_c = merged;
      KIND_AND,
      KIND_VAR:    res_c = anded;
      default:     res_c = '0;
    endcase
  end

  rotmask_flags #(.W(DATA_W)) u_flags (
    .value(res_c), .ovf(sum_ovf_in), .field(flags_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_data  <= '0;
      flag_we   <= 1'b0;
      flag_val  <= '0;
      bad_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_data <= res_c;
        bad_op   <= (kind == KIND_BAD);
        flag_we  <= upd_flags && (kind != KIND_BAD);
        flag_val <= (upd_flags && (kind != KIND_BAD)) ? flags_c : 4'h0;
      end else begin
        flag_we <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk
  import rotmask_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OPC_W-1:0]  ctl_opcode,
  input logic [DATA_W-1:0] src_word,
  input logic [SH_W-1:0]   sh_imm,
  input logic [SH_W-1:0]   msk_first,
  input logic [SH_W-1:0]   msk_last,
  input logic              sum_ovf_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              flag_we,
  input logic [3:0]        flag_val,
  input logic              bad_op
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R10: valid is delayed by one clock
  p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid)));

  // R9: unsupported opcode gives zero result and no flag write
  p_bad_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_op) |-> (res_data == '0 && !flag_we));

  // R9: bad_op tracks the opcode presented one cycle earlier
  p_bad_decode_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid)) |->
      (bad_op == !($past(ctl_opcode) == OPC_RL_INSERT ||
                   $past(ctl_opcode) == OPC_RL_AND ||
                   $past(ctl_opcode) == OPC_RL_VAR)));

  // R4: zero immediate rotate with a full mask returns the source
  p_zero_rot_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && ctl_opcode == OPC_RL_AND && sh_imm == '0 &&
                    msk_first == '0 && msk_last == SH_W'(DATA_W - 1)))
      |-> (res_data == $past(src_word)));

  // R7: exactly one of LT/GT/EQ, and SO follows the input
  p_flags_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> ($countones(flag_val[3:1]) == 1 && flag_val[0] == $past(sum_ovf_in)));

  // R10: no flag write without a valid result
  p_we_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> out_valid);
endmodule

bind rotmask_unit rotmask_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ctl_opcode(ctl_opcode),
  .src_word(src_word), .sh_imm(sh_imm), .msk_first(msk_first),
  .msk_last(msk_last), .sum_ovf_in(sum_ovf_in), .out_valid(out_valid),
  .res_data(res_data), .flag_we(flag_we), .flag_val(flag_val), .bad_op(bad_op)
);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  ctl_opcode = '0;
  logic [31:0] src_word = '0, amt_reg = '0, old_dest = '0;
  logic [4:0]  sh_imm = '0, msk_first = '0, msk_last = '0;
  logic        upd_flags = 1'b0, sum_ovf_in = 1'b0;
  logic        out_valid, flag_we, bad_op;
  logic [31:0] res_data;
  logic [3:0]  flag_val;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rotmask_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctl_opcode(ctl_opcode),
    .src_word(src_word), .amt_reg(amt_reg), .old_dest(old_dest),
    .sh_imm(sh_imm), .msk_first(msk_first), .msk_last(msk_last),
    .upd_flags(upd_flags), .sum_ovf_in(sum_ovf_in), .out_valid(out_valid),
    .res_data(res_data), .flag_we(flag_we), .flag_val(flag_val), .bad_op(bad_op)
  );

  function automatic logic [31:0] m_rotl(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] m_mask(input int b, input int e);
    logic [31:0] m = '0;
    for (int j = 0; j < 32; j++)
      if ((b <= e) ? (j >= b && j <= e) : (j >= b || j <= e)) m[31-j] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [5:0] op, input logic [31:0] src,
                        input logic [31:0] amt, input logic [31:0] old, input int sh,
                        input int b, input int e, input bit rec, input bit ovf);
    logic [31:0] r, m, exp_res;
    logic legal;
    logic [3:0] exp_f;
    legal = (op == 6'h14 || op == 6'h15 || op == 6'h17);
    r = m_rotl(src, (op == 6'h17) ? int'(amt[4:0]) : sh);
    m = m_mask(b, e);
    exp_res = !legal ? 32'h0 : (op == 6'h14) ? ((r & m) | (old & ~m)) : (r & m);
    exp_f = {$signed(exp_res) < 0, $signed(exp_res) > 0, exp_res == 0, ovf};
    @(negedge clk);
    in_valid = 1'b1; ctl_opcode = op; src_word = src; amt_reg = amt; old_dest = old;
    sh_imm = 5'(sh); msk_first = 5'(b); msk_last = 5'(e); upd_flags = rec; sum_ovf_in = ovf;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", 32'(out_valid), 32'd1);
    check(req, "res_data", res_data, exp_res);
    check(req, "bad_op", 32'(bad_op), 32'(!legal));
    check(req, "flag_we", 32'(flag_we), 32'(rec && legal));
    if (rec && legal) check(req, "flag_val", 32'(flag_val), 32'(exp_f));
  endtask

  task automatic t_reset;
    check("R11", "out_valid", 32'(out_valid), 0);
    check("R11", "res_data", res_data, 0);
    check("R11", "flag_we", 32'(flag_we), 0);
    check("R11", "bad_op", 32'(bad_op), 0);
  endtask

  task automatic t_and_mask;
    run_op("R1", 6'h15, 32'h1234_5678, 32'h0, 32'h0, 8, 0, 31, 0, 0);
    run_op("R1", 6'h15, 32'h1234_5678, 32'h0, 32'h0, 8, 8, 15, 0, 0);
    run_op("R5", 6'h15, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 4, 27, 0, 0);
    run_op("R5", 6'h15, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 13, 13, 0, 0);
  endtask

  task automatic t_insert;
    run_op("R2", 6'h14, 32'h0000_00AB, 32'h0, 32'hDEAD_BEEF, 16, 8, 15, 0, 0);
    run_op("R2", 6'h14, 32'hCAFE_F00D, 32'h0, 32'h5555_5555, 31, 30, 1, 0, 0);
  endtask

  task automatic t_var_rot;
    run_op("R3", 6'h17, 32'h8000_0001, 32'hFFFF_FFE3, 32'h0, 17, 0, 31, 0, 0);
    run_op("R3", 6'h17, 32'h0F0F_1234, 32'h0000_0020, 32'h0, 9, 0, 31, 0, 0);
  endtask

  task automatic t_zero_rot;
    run_op("R4", 6'h15, 32'h89AB_CDEF, 32'h0, 32'h0, 0, 0, 31, 0, 0);
    run_op("R4", 6'h17, 32'h7654_3210, 32'hFFFF_FFE0, 32'h0, 5, 0, 31, 0, 0);
  endtask

  task automatic t_wrap;
    run_op("R6", 6'h15, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 28, 3, 0, 0);
    run_op("R6", 6'h15, 32'hA5A5_A5A5, 32'h0, 32'h0, 3, 31, 0, 0, 0);
  endtask

  task automatic t_record;
    run_op("R7", 6'h15, 32'h8000_0000, 32'h0, 32'h0, 0, 0, 31, 1, 0);
    run_op("R7", 6'h15, 32'h0000_0010, 32'h0, 32'h0, 0, 0, 31, 1, 1);
    run_op("R7", 6'h15, 32'hFFFF_0000, 32'h0, 32'h0, 0, 16, 31, 1, 1);
    run_op("R8", 6'h15, 32'h0000_0010, 32'h0, 32'h0, 0, 0, 31, 0, 1);
  endtask

  task automatic t_illegal;
    run_op("R9", 6'h16, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 4, 0, 31, 1, 1);
    run_op("R9", 6'h00, 32'h1234_5678, 32'h0, 32'h0, 0, 0, 31, 0, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    check("R10", "out_valid idle", 32'(out_valid), 0);
    check("R10", "flag_we idle", 32'(flag_we), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_and_mask();
    t_latency();
    t_insert();
    t_var_rot();
    t_zero_rot();
    t_wrap();
    t_record();
    t_illegal();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule